// File: doc/BRIEF.md
# Nibble-Buffered Serial Write Transmitter

This block is a transmit-only serial output for a small microcontroller. The CPU places a 4-bit value in a holding register and sets a start control bit. The block then moves the value into an internal shift register. It clocks the bits out on a serial clock and serial data pair, least significant bit first. The serial clock rate follows one of four prescaler tap levels, chosen by a 2-bit select field. The taps are conventionally about 1, 2, 8 and 16 kHz, with the lowest index the slowest.

Each move from the holding register into the shift register sets an empty flag. While the start bit is set, that flag is also a non-maskable interrupt request. The CPU answers by writing the next value. If the write lands before the serial clock falls on the last bit of the current value, the next value follows with no gap in the clock. A stream of any length is possible this way. If no reload arrives, the interrupt stays asserted and the start bit clears itself once the last value has been shifted out. Software can also clear the start bit, which stops the transfer at once.

An optional mode releases the outputs from high impedance only while the start bit is set.

Top module: `nst_serial_tx`

## Requirements
- R1: `sel_i` picks `tap_i[sel_i]`. Each rising edge of that tap during a transfer produces one rising edge of `sclk_o`, so consecutive `sclk_o` rises are one tap period apart.
- R2: A start write (`start_we_i`=1, `start_d_i`=1) with a full holding register loads the shift register and sets `start_o` on the next cycle. With an empty holding register, `start_o` stays 0 and no clock is produced.
- R3: Each transfer from the holding register to the shift register sets `empty_o`. `irq_o` equals `empty_o` while `start_o` is 1.
- R4: A holding write (`hold_we_i`=1) clears `empty_o` and `irq_o` on the next cycle. A write while the register is still full replaces the held value and leaves the value being shifted untouched.
- R5: Bits leave least significant first, so bit 3 is the last bit. `sdo_o` changes when `sclk_o` rises. `sclk_o` and `sdo_o` are 0 whenever `start_o` is 0.
- R6: If the holding register is written before `sclk_o` falls on bit 3, the new value starts on the next tap rise with no gap.
- R7: If no reload arrives by the falling edge of bit 3, `start_o` clears on that edge and `irq_o` stays 1 until then. A later holding write starts nothing.
- R8: A stop write (`start_we_i`=1, `start_d_i`=0) clears `start_o`, `sclk_o` and `sdo_o` on the next cycle, even mid-value. No further clock edges follow.
- R9: With `hiz_mode_i`=1, `oe_o` is 0 while idle, 1 from the cycle after start, and 0 again as soon as the transfer ends. With `hiz_mode_i`=0, `oe_o` is always 1.
- R10: After reset, `start_o`, `empty_o`, `irq_o`, `sclk_o` and `sdo_o` are 0 and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tap_i | input | 4 | Prescaler tap levels, index 0 slowest |
| sel_i | input | 2 | Rate select, indexes tap_i |
| hiz_mode_i | input | 1 | Tri-state outputs while idle |
| hold_we_i | input | 1 | Holding register write strobe |
| hold_d_i | input | 4 | Holding register write data |
| start_we_i | input | 1 | Start bit write strobe |
| start_d_i | input | 1 | Start bit write value |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data |
| oe_o | output | 1 | Output enable for the serial pins |
| start_o | output | 1 | Start bit readback |
| empty_o | output | 1 | Holding register empty flag |
| irq_o | output | 1 | Empty interrupt request |

## Verification
The assertions rely on the CPU never writing the holding register and the start bit in the same cycle. They also rely on `sel_i` holding steady during a transfer and on each tap staying at one level for at least two clocks. The stimulus keeps within these limits by construction: taps come from a free-running counter, the select changes only while idle, and holding and start writes are issued by separate tasks. Random reload delays of 0 to 2 cycles after the interrupt always fall well before the bit-3 falling edge, even at the fastest tap. Late reloads are produced only in directed cases.

// File: rtl/nst_pkg.sv
package nst_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } tap_edge_t;
endpackage

// File: rtl/nst_tap_sel.sv
module nst_tap_sel
  import nst_pkg::*;
#(
  parameter int NUM_TAPS = 4,
  localparam int SEL_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [SEL_W-1:0]    sel_i,
  output tap_edge_t           edge_o
);
  logic cur;
  logic prev_q;

  assign cur = tap_i[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  assign edge_o.rise = cur & ~prev_q;
  assign edge_o.fall = ~cur & prev_q;
endmodule

// File: rtl/nst_hold.sv
module nst_hold #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      flag_o <= 1'b0;
    end else if (wr_i) begin
      // a write wins over a same-cycle transfer: the shifter took the old value
      data_o <= wdata_i;
      full_o <= 1'b1;
      flag_o <= 1'b0;
    end else if (load_i) begin
      full_o <= 1'b0;
      flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/nst_shifter.sv
module nst_shifter
  import nst_pkg::*;
#(
  parameter int W = 4,
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_set_i,
  input  logic         start_clr_i,
  input  tap_edge_t    edge_i,
  input  logic         hold_full_i,
  input  logic [W-1:0] hold_data_i,
  output logic         load_o,
  output logic         active_o,
  output logic         sclk_o,
  output logic         sdo_o
);
  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_bit;
  logic             start_go;
  logic             nib_end;

  assign last_bit = (cnt_q == CNT_W'(W - 1));
  assign start_go = start_set_i & ~active_o & hold_full_i;
  assign nib_end  = active_o & edge_i.fall & sclk_o & last_bit;
  assign load_o   = ~start_clr_i & (start_go | (nib_end & hold_full_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      sclk_o   <= 1'b0;
      sdo_o    <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
    end else if (start_clr_i) begin
      active_o <= 1'b0;
      sclk_o   <= 1'b0;
      sdo_o    <= 1'b0;
      cnt_q    <= '0;
    end else if (start_go) begin
      active_o <= 1'b1;
      shreg_q  <= hold_data_i;
      cnt_q    <= '0;
      sclk_o   <= 1'b0;
      sdo_o    <= 1'b0;
    end else if (active_o) begin
      if (edge_i.rise && !sclk_o) begin
        sclk_o <= 1'b1;
        sdo_o  <= shreg_q[cnt_q];
      end else if (edge_i.fall && sclk_o) begin
        sclk_o <= 1'b0;
        if (!last_bit) begin
          cnt_q <= cnt_q + 1'b1;
        end else if (hold_full_i) begin
          shreg_q <= hold_data_i;
          cnt_q   <= '0;
        end else begin
          active_o <= 1'b0;
          sdo_o    <= 1'b0;
          cnt_q    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/nst_serial_tx.sv
module nst_serial_tx
  import nst_pkg::*;
#(
  parameter int NUM_TAPS = 4,
  parameter int W        = 4,
  localparam int SEL_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                hiz_mode_i,
  input  logic                hold_we_i,
  input  logic [W-1:0]        hold_d_i,
  input  logic                start_we_i,
  input  logic                start_d_i,
  output logic                sclk_o,
  output logic                sdo_o,
  output logic                oe_o,
  output logic                start_o,
  output logic                empty_o,
  output logic                irq_o
);
  tap_edge_t    tap_edge;
  logic         load;
  logic         hold_full;
  logic         flag;
  logic [W-1:0] hold_data;

  nst_tap_sel #(.NUM_TAPS(NUM_TAPS)) u_tap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_i  (tap_i),
    .sel_i  (sel_i),
    .edge_o (tap_edge)
  );

  nst_hold #(.W(W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (hold_we_i),
    .wdata_i (hold_d_i),
    .load_i  (load),
    .data_o  (hold_data),
    .full_o  (hold_full),
    .flag_o  (flag)
  );

  nst_shifter #(.W(W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_set_i (start_we_i & start_d_i),
    .start_clr_i (start_we_i & ~start_d_i),
    .edge_i      (tap_edge),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .load_o      (load),
    .active_o    (start_o),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o)
  );

  assign empty_o = flag;
  assign irq_o   = flag & start_o;
  assign oe_o    = hiz_mode_i ? start_o : 1'b1;
endmodule

// File: rtl/nst_serial_tx_chk.sv
module nst_serial_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_we_i,
  input logic start_we_i,
  input logic start_d_i,
  input logic hold_full,
  input logic sclk_o,
  input logic sdo_o,
  input logic start_o,
  input logic empty_o,
  input logic irq_o
);
  p_wr_clears_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_we_i |=> (!empty_o && !irq_o));

  p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_we_i && start_d_i && !start_o && hold_full && !hold_we_i)
      |=> (start_o && empty_o && irq_o));

  p_empty_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_we_i && start_d_i && !start_o && !hold_full) |=> !start_o);

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_we_i && !start_d_i) |=> (!start_o && !sclk_o && !sdo_o));

  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> (!sclk_o && !sdo_o));

  p_auto_stop_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(start_o) && !$past(start_we_i)) |-> ($past(sclk_o) && !sclk_o));
endmodule

bind nst_serial_tx nst_serial_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_we_i  (hold_we_i),
  .start_we_i (start_we_i),
  .start_d_i  (start_d_i),
  .hold_full  (hold_full),
  .sclk_o     (sclk_o),
  .sdo_o      (sdo_o),
  .start_o    (start_o),
  .empty_o    (empty_o),
  .irq_o      (irq_o)
);

// File: tb/nst_serial_tx_test.sv
module nst_serial_tx_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] tap_i;
  logic [1:0] sel_i = 2'd0;
  logic       hiz_mode_i = 1'b0;
  logic       hold_we_i = 1'b0;
  logic [3:0] hold_d_i = 4'd0;
  logic       start_we_i = 1'b0;
  logic       start_d_i = 1'b0;
  logic       sclk_o, sdo_o, oe_o, start_o, empty_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [7:0] tcnt = 8'd0;
  logic sclk_prev = 1'b0;
  logic rise_bits[$];
  int   rise_cyc[$];
  logic [3:0] expq[$];

  always #10 clk_i = ~clk_i;

  // taps: index 0 period 64, 1 period 32, 2 period 8, 3 period 4
  assign tap_i = {tcnt[1], tcnt[2], tcnt[4], tcnt[5]};

  always @(negedge clk_i) begin
    tcnt = tcnt + 8'd1;
    cyc  = cyc + 1;
    if (sclk_o && !sclk_prev) begin
      rise_bits.push_back(sdo_o);
      rise_cyc.push_back(cyc);
    end
    sclk_prev = sclk_o;
  end

  nst_serial_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tap_i(tap_i), .sel_i(sel_i),
    .hiz_mode_i(hiz_mode_i), .hold_we_i(hold_we_i), .hold_d_i(hold_d_i),
    .start_we_i(start_we_i), .start_d_i(start_d_i), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .oe_o(oe_o), .start_o(start_o), .empty_o(empty_o),
    .irq_o(irq_o)
  );

  always @(posedge clk_i) begin
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input logic [1:0] s);
    case (s)
      2'd0: return 64;
      2'd1: return 32;
      2'd2: return 8;
      default: return 4;
    endcase
  endfunction

  task automatic wr_hold(input logic [3:0] d);
    @(negedge clk_i); hold_we_i = 1'b1; hold_d_i = d;
    @(negedge clk_i); hold_we_i = 1'b0;
  endtask

  task automatic wr_start(input logic v);
    @(negedge clk_i); start_we_i = 1'b1; start_d_i = v;
    @(negedge clk_i); start_we_i = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 4000 && !irq_o; i++) @(negedge clk_i);
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 4000 && start_o; i++) @(negedge clk_i);
  endtask

  task automatic clear_log();
    rise_bits.delete(); rise_cyc.delete(); expq.delete();
  endtask

  // compare captured stream against queued nibbles, LSB first, gapless
  task automatic check_stream(input logic [1:0] s, input string tag);
    int bad = 0;
    int gaps = 0;
    chk(rise_bits.size() == 4 * expq.size(), {tag, " R6 edge count"},
        rise_bits.size(), 4 * expq.size());
    for (int i = 0; i < rise_bits.size() && i < 4 * expq.size(); i++)
      if (rise_bits[i] !== expq[i / 4][i % 4]) bad++;
    chk(bad == 0, {tag, " R5 lsb-first bits"}, bad, 0);
    for (int i = 1; i < rise_cyc.size(); i++)
      if (rise_cyc[i] - rise_cyc[i-1] != period_of(s)) gaps++;
    chk(gaps == 0, {tag, " R1 R6 clock period"}, gaps, 0);
  endtask

  task automatic run_stream(input logic [1:0] s, input int n, input bit hiz, input bit dbl);
    logic [3:0] d;
    bit irq_ok = 1'b1;
    bit clr_ok = 1'b1;
    sel_i = s; hiz_mode_i = hiz;
    repeat (3) @(negedge clk_i);
    clear_log();
    if (hiz) chk(oe_o == 1'b0, "R9 idle oe", oe_o, 0);
    d = 4'($urandom); wr_hold(d);
    if (dbl) begin d = 4'($urandom); wr_hold(d); end
    expq.push_back(d);
    wr_start(1'b1);
    chk(start_o && empty_o && irq_o, "R2 R3 start loads", {start_o, empty_o, irq_o}, 7);
    if (hiz) chk(oe_o == 1'b1, "R9 oe after start", oe_o, 1);
    for (int i = 1; i < n; i++) begin
      wait_irq();
      repeat ($urandom % 3) @(negedge clk_i);
      d = 4'($urandom); wr_hold(d);
      if (irq_o || empty_o) clr_ok = 1'b0;
      if (dbl && (i % 2 == 1)) begin d = 4'($urandom); wr_hold(d); end
      expq.push_back(d);
    end
    wait_irq();
    while (start_o) begin
      if (!irq_o) irq_ok = 1'b0;
      @(negedge clk_i);
    end
    if (n > 1) chk(clr_ok, "R4 write clears flag", clr_ok, 1);
    chk(irq_ok, "R7 irq held to stop", irq_ok, 1);
    chk(!sclk_o && !sdo_o, "R5 idle low after stop", {sclk_o, sdo_o}, 0);
    chk(oe_o == !hiz, "R9 oe after stop", oe_o, !hiz);
    check_stream(s, dbl ? "overwrite" : "stream");
  endtask

  initial begin
    int nr;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk({start_o, empty_o, irq_o, sclk_o, sdo_o} == 5'd0, "R10 reset outputs",
        {start_o, empty_o, irq_o, sclk_o, sdo_o}, 0);
    chk(oe_o == 1'b1, "R9 oe without hiz", oe_o, 1);

    // R2 start with empty holding register
    nr = rise_bits.size();
    wr_start(1'b1);
    chk(start_o == 1'b0, "R2 empty start ignored", start_o, 0);
    repeat (80) @(negedge clk_i);
    chk(rise_bits.size() == nr, "R2 no clock on empty start", rise_bits.size(), nr);

    // single nibble, overwrite before start (R4)
    sel_i = 2'd2; repeat (3) @(negedge clk_i); clear_log();
    wr_hold(4'h3); wr_hold(4'hA); expq.push_back(4'hA);
    wr_start(1'b1);
    wait_stop();
    check_stream(2'd2, "R4 overwrite-before-start");

    // late reload: no restart after auto stop (R7)
    wr_hold(4'h6);
    nr = rise_bits.size();
    repeat (60) @(negedge clk_i);
    chk(start_o == 1'b0 && rise_bits.size() == nr, "R7 late write starts nothing",
        rise_bits.size(), nr);

    // streams at each rate
    run_stream(2'd0, 3, 1'b0, 1'b0);
    run_stream(2'd1, 4, 1'b1, 1'b0);
    run_stream(2'd2, 8, 1'b0, 1'b1);
    run_stream(2'd3, 12, 1'b1, 1'b0);
    run_stream(2'd3, 6, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++)
      run_stream(2'($urandom), 2 + ($urandom % 5), 1'($urandom), 1'($urandom));

    // R8 abort mid-nibble
    sel_i = 2'd0; hiz_mode_i = 1'b1; repeat (3) @(negedge clk_i);
    clear_log();
    wr_hold(4'h9); wr_hold(4'h5);
    wr_start(1'b1);
    for (int i = 0; i < 2000 && rise_bits.size() < 2; i++) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    wr_start(1'b0);
    chk(!start_o && !sclk_o && !sdo_o, "R8 stop clears outputs",
        {start_o, sclk_o, sdo_o}, 0);
    chk(oe_o == 1'b0, "R9 oe off after stop", oe_o, 0);
    nr = rise_bits.size();
    repeat (200) @(negedge clk_i);
    chk(rise_bits.size() == nr, "R8 no edges after stop", rise_bits.size(), nr);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule